// File: doc/BRIEF.md
# Producer-Driven Quadword Receive Channel

This block is a receive-only DMA channel. It never fetches anything itself. An external producer pushes 128-bit quadwords into it over a valid/ready stream, and the channel writes each accepted quadword to one of two memories. Setting the start bit only arms the channel. Data moves only when the producer offers it.

Software loads three registers: a control word, a byte address and a remaining-quadword count. Address bit 31 selects the target memory. When it is set, writes go to the scratchpad port and the address wraps at the scratchpad size. When it is clear, writes go to the main-RAM port and the address wraps at the RAM size. Each accepted quadword moves the address forward by 16 bytes and lowers the count by one. When the count reaches zero, the channel disarms itself and sends a one-cycle completion pulse to the status logic.

Top module: `qw_rx_channel`

## Requirements
- R1: After reset, the control, address and count registers all read zero. `push_ready`, `spr_we`, `ram_we` and `done` are all low.
- R2: Register select 0 writes the control word, 1 writes the address and 2 writes the count. A control write stores all 32 bits as given. The start bit is bit 8. A control write causes no memory write unless a quadword is pushed.
- R3: While control bit 8 is clear, `push_ready` is low and no quadword is accepted.
- R4: While the count is zero, `push_ready` is low even if the start bit is set.
- R5: When a producer offers N quadwords back to back to an armed channel, exactly min(N, count) of them are accepted.
- R6: A quadword is accepted on a clock edge where `push_valid` and `push_ready` are both high. On the next cycle exactly one memory write strobe is high, carrying the pushed data. If address bit 31 was set, it is `spr_we` with quadword index address[SPR_AW-1:4]. Otherwise it is `ram_we` with quadword index address[RAM_AW-1:4].
- R7: Each accepted quadword adds 16 to the 32-bit address and subtracts 1 from the count, unless that register is written in the same cycle.
- R8: An address write stores the value with bits 3:0 forced to zero.
- R9: When the count reaches zero through an acceptance, control bit 8 clears and `done` is high for exactly one cycle. Both happen on the cycle after the final acceptance. All other control bits are kept.
- R10: When a register write and an acceptance fall in the same cycle, the written register takes the written value. A count write in that cycle suppresses completion. A completion clears bit 8 even when a control write in the same cycle sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 address, 2 count |
| reg_wdata | input | 32 | Register write data |
| push_valid | input | 1 | Producer offers a quadword |
| push_data | input | 128 | Offered quadword |
| push_ready | output | 1 | Channel can accept a quadword |
| ctl_q | output | 32 | Control register value |
| addr_q | output | 32 | Current byte address |
| cnt_q | output | CNT_W | Remaining quadword count |
| spr_we | output | 1 | Scratchpad write strobe |
| spr_qaddr | output | SPR_AW-4 | Scratchpad quadword index |
| spr_wdata | output | 128 | Scratchpad write data |
| ram_we | output | 1 | Main-RAM write strobe |
| ram_qaddr | output | RAM_AW-4 | Main-RAM quadword index |
| ram_wdata | output | 128 | Main-RAM write data |
| done | output | 1 | One-cycle completion pulse |

## Verification
A software register write and a producer acceptance can land on the same clock edge. The bench forces this in two ways:
- It rewrites the count in the middle of a stream. The count must take the new value and the address must still advance.
- It writes a control word with bit 8 set on the edge of the final acceptance. The stored word must keep the written bits with bit 8 cleared, and exactly one completion pulse must follow.

A sweep covers every mix of start state, initial count 0 to 4, offered length 0 to 5, and four base addresses (two of them wrap a memory). It checks the acceptance count, the final registers and every memory strobe.

// File: rtl/qw_rx_channel.sv
module qw_rx_channel #(
  parameter int CNT_W     = 16,
  parameter int SPR_AW    = 14,
  parameter int RAM_AW    = 25,
  parameter int START_BIT = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [1:0]          reg_sel,
  input  logic [31:0]         reg_wdata,
  input  logic                push_valid,
  input  logic [127:0]        push_data,
  output logic                push_ready,
  output logic [31:0]         ctl_q,
  output logic [31:0]         addr_q,
  output logic [CNT_W-1:0]    cnt_q,
  output logic                spr_we,
  output logic [SPR_AW-5:0]   spr_qaddr,
  output logic [127:0]        spr_wdata,
  output logic                ram_we,
  output logic [RAM_AW-5:0]   ram_qaddr,
  output logic [127:0]        ram_wdata,
  output logic                done
);
  localparam logic [1:0] SEL_CTL  = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_CNT  = 2'd2;

  logic         wr_ctl, wr_addr, wr_cnt, accept, last;
  logic [127:0] wd_q;

  assign wr_ctl     = reg_we && (reg_sel == SEL_CTL);
  assign wr_addr    = reg_we && (reg_sel == SEL_ADDR);
  assign wr_cnt     = reg_we && (reg_sel == SEL_CNT);
  assign push_ready = ctl_q[START_BIT] && (cnt_q != '0);
  assign accept     = push_valid && push_ready;
  assign last       = accept && (cnt_q == CNT_W'(1)) && !wr_cnt;

  assign spr_wdata = wd_q;
  assign ram_wdata = wd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q     <= '0;
      addr_q    <= '0;
      cnt_q     <= '0;
      spr_we    <= 1'b0;
      ram_we    <= 1'b0;
      spr_qaddr <= '0;
      ram_qaddr <= '0;
      wd_q      <= '0;
      done      <= 1'b0;
    end else begin
      if (wr_ctl) ctl_q <= reg_wdata;
      if (last)   ctl_q[START_BIT] <= 1'b0;

      if (wr_addr)     addr_q <= {reg_wdata[31:4], 4'b0000};
      else if (accept) addr_q <= addr_q + 32'd16;

      if (wr_cnt)      cnt_q <= reg_wdata[CNT_W-1:0];
      else if (accept) cnt_q <= cnt_q - CNT_W'(1);

      spr_we <= accept && addr_q[31];
      ram_we <= accept && !addr_q[31];
      if (accept) begin
        spr_qaddr <= addr_q[SPR_AW-1:4];
        ram_qaddr <= addr_q[RAM_AW-1:4];
        wd_q      <= push_data;
      end
      done <= last;
    end
  end
endmodule

module qw_rx_channel_chk #(
  parameter int CNT_W     = 16,
  parameter int START_BIT = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic             push_valid,
  input logic             push_ready,
  input logic [31:0]      ctl_q,
  input logic [31:0]      addr_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             spr_we,
  input logic             ram_we,
  input logic             done
);
  // R3
  idle_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[START_BIT] |-> !push_ready);
  // R4
  empty_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |-> !push_ready);
  // R6
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({spr_we, ram_we}));
  // R6
  accept_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && push_ready) |=> (spr_we || ram_we));
  // R7
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && push_ready && !reg_we) |=>
      (addr_q == $past(addr_q) + 32'd16) && (cnt_q == $past(cnt_q) - CNT_W'(1)));
  // R8
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_q[3:0] == 4'h0);
  // R9
  done_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!ctl_q[START_BIT] && cnt_q == '0));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind qw_rx_channel qw_rx_channel_chk #(.CNT_W(CNT_W), .START_BIT(START_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .push_valid(push_valid),
  .push_ready(push_ready), .ctl_q(ctl_q), .addr_q(addr_q), .cnt_q(cnt_q),
  .spr_we(spr_we), .ram_we(ram_we), .done(done)
);

// File: tb/tb_qw_rx_channel.sv
module tb_qw_rx_channel;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int SPR_AW = 14;
  localparam int RAM_AW = 25;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [1:0] reg_sel = 0;
  logic [31:0] reg_wdata = 0;
  logic push_valid = 0;
  logic [127:0] push_data = 0;
  logic push_ready;
  logic [31:0] ctl_q, addr_q;
  logic [CNT_W-1:0] cnt_q;
  logic spr_we, ram_we, done;
  logic [SPR_AW-5:0] spr_qaddr;
  logic [RAM_AW-5:0] ram_qaddr;
  logic [127:0] spr_wdata, ram_wdata;

  qw_rx_channel #(.CNT_W(CNT_W), .SPR_AW(SPR_AW), .RAM_AW(RAM_AW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .push_valid(push_valid), .push_data(push_data), .push_ready(push_ready),
    .ctl_q(ctl_q), .addr_q(addr_q), .cnt_q(cnt_q),
    .spr_we(spr_we), .spr_qaddr(spr_qaddr), .spr_wdata(spr_wdata),
    .ram_we(ram_we), .ram_qaddr(ram_qaddr), .ram_wdata(ram_wdata), .done(done));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int spr_n = 0, ram_n = 0, done_n = 0, mon_idx = 0;
  logic [31:0] mon_base = 0;
  logic [31:0] mon_tag = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] pat(input logic [31:0] tag, input int k);
    return {tag, 64'h0123_4567_89AB_CDEF, 32'(k)};
  endfunction

  // memory port monitor, R6
  always @(negedge clk) begin
    if (rst_n) begin
      logic [31:0] ea;
      ea = mon_base + 32'(16 * mon_idx);
      if (spr_we) begin
        chk(mon_base[31], "R6 route spr", 1, mon_base[31]);
        chk(spr_qaddr == ea[SPR_AW-1:4], "R6 spr index", spr_qaddr, ea[SPR_AW-1:4]);
        chk(spr_wdata == pat(mon_tag, mon_idx), "R6 spr data", spr_wdata[31:0], mon_idx);
        spr_n++; mon_idx++;
      end
      if (ram_we) begin
        chk(!mon_base[31], "R6 route ram", 0, mon_base[31]);
        chk(ram_qaddr == ea[RAM_AW-1:4], "R6 ram index", ram_qaddr, ea[RAM_AW-1:4]);
        chk(ram_wdata == pat(mon_tag, mon_idx), "R6 ram data", ram_wdata[31:0], mon_idx);
        ram_n++; mon_idx++;
      end
      if (done) done_n++;
    end
  end

  // tasks enter and leave at a falling edge
  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    reg_we = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic mon_reset(input logic [31:0] base, input logic [31:0] tag);
    mon_base = {base[31:4], 4'h0}; mon_tag = tag;
    spr_n = 0; ram_n = 0; done_n = 0; mon_idx = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int vec = 0;
    logic [31:0] bases [4];
    bases[0] = 32'h0000_1238; bases[1] = 32'h8000_3FE7;
    bases[2] = 32'h01FF_FFE0; bases[3] = 32'h8123_4560;
    repeat (3) @(negedge clk);
    // R1
    chk(ctl_q == 0 && addr_q == 0 && cnt_q == 0, "R1 regs", {ctl_q, addr_q}, 0);
    chk(!push_ready && !spr_we && !ram_we && !done, "R1 outputs",
        {push_ready, spr_we, ram_we, done}, 0);
    rst_n = 1;
    @(negedge clk);

    // R2: control write stores whole word and moves nothing
    mon_reset(32'h0, 32'h0);
    wr(2, 3);
    wr(0, 32'hDEAD_01F0);
    repeat (5) @(negedge clk);
    chk(ctl_q == 32'hDEAD_01F0, "R2 ctl value", ctl_q, 32'hDEAD_01F0);
    chk(spr_n + ram_n == 0, "R2 no writes", spr_n + ram_n, 0);
    chk(cnt_q == 3, "R2 count kept", cnt_q, 3);
    wr(0, 0);
    wr(2, 0);
    // R3: bit 8 clear while count nonzero
    wr(2, 2);
    chk(!push_ready, "R3 ready idle", push_ready, 0);
    // R4
    wr(0, 32'h100); wr(2, 0);
    chk(!push_ready, "R4 ready empty", push_ready, 0);

    // sweep: R5 R7 R8 R9 R3 R4
    for (int b = 0; b < 4; b++)
      for (int st = 0; st < 2; st++)
        for (int c0 = 0; c0 < 5; c0++)
          for (int off = 0; off < 6; off++) begin
            int acc, expacc;
            bit expdone;
            vec++;
            wr(0, 0);
            wr(1, bases[b]);
            chk(addr_q == {bases[b][31:4], 4'h0}, "R8 addr mask", addr_q, {bases[b][31:4], 4'h0});
            wr(2, 32'(c0));
            wr(0, st ? 32'h0000_0105 : 32'h0000_0005);
            mon_reset(bases[b], 32'(vec));
            acc = 0;
            for (int k = 0; k < off; k++) begin
              push_valid = 1; push_data = pat(32'(vec), k);
              #1;
              if (!push_ready) break;
              @(negedge clk);
              acc++;
            end
            push_valid = 0;
            repeat (2) @(negedge clk);
            expacc = st ? ((off < c0) ? off : c0) : 0;
            expdone = st && c0 > 0 && expacc == c0;
            chk(acc == expacc, "R5 accepted", acc, expacc);
            chk(cnt_q == CNT_W'(c0 - expacc), "R7 count", cnt_q, c0 - expacc);
            chk(addr_q == {bases[b][31:4], 4'h0} + 32'(16 * expacc), "R7 addr", addr_q,
                {bases[b][31:4], 4'h0} + 32'(16 * expacc));
            chk(spr_n + ram_n == expacc, "R6 write count", spr_n + ram_n, expacc);
            chk(done_n == int'(expdone), "R9 done pulses", done_n, expdone);
            chk(ctl_q == ((st && !expdone) ? 32'h105 : 32'h005), "R9 ctl after", ctl_q,
                (st && !expdone) ? 32'h105 : 32'h005);
          end

    // R10: count rewrite during streaming
    wr(0, 0); wr(1, 32'h0000_0100); wr(2, 3);
    mon_reset(32'h0000_0100, 32'hC0);
    wr(0, 32'h100);
    push_valid = 1; push_data = pat(32'hC0, 0);
    @(negedge clk);
    push_data = pat(32'hC0, 1);
    reg_we = 1; reg_sel = 2; reg_wdata = 5;
    @(negedge clk);
    reg_we = 0; push_valid = 0;
    repeat (2) @(negedge clk);
    chk(cnt_q == 5, "R10 count write wins", cnt_q, 5);
    chk(addr_q == 32'h120, "R10 addr still moves", addr_q, 32'h120);
    chk(ctl_q[8] && done_n == 0, "R10 no completion", done_n, 0);
    for (int k = 2; k < 7; k++) begin
      push_valid = 1; push_data = pat(32'hC0, k);
      @(negedge clk);
    end
    push_valid = 0;
    repeat (2) @(negedge clk);
    chk(done_n == 1 && cnt_q == 0, "R9 done after rewrite", done_n, 1);
    chk(addr_q == 32'h170, "R7 addr after rewrite", addr_q, 32'h170);

    // R10: control write on the final acceptance edge
    wr(1, 32'h8000_0040); wr(2, 1);
    mon_reset(32'h8000_0040, 32'hD0);
    wr(0, 32'h100);
    push_valid = 1; push_data = pat(32'hD0, 0);
    reg_we = 1; reg_sel = 0; reg_wdata = 32'h0000_0105;
    @(negedge clk);
    reg_we = 0; push_valid = 0;
    repeat (2) @(negedge clk);
    chk(ctl_q == 32'h0000_0005, "R10 completion beats ctl write", ctl_q, 32'h5);
    chk(done_n == 1 && spr_n == 1, "R10 single completion", done_n, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule